// File: doc/BRIEF.md
# Burst Read Engine with Stream Output

This block moves a contiguous region of memory into a streaming pipeline. A command interface supplies a 64-bit base address and a byte count and starts the engine with a one-cycle pulse. The engine breaks the region into AXI read bursts and issues them on the read-address channel. It then forwards each returned 32-bit word, in order, on an AXI4-Stream master port. When the last word has been taken by the stream consumer, it raises a one-cycle completion pulse.

A typical use is filling an on-chip table, such as a glyph memory, once after power-up. The stream consumer can stall at any time. The read-data channel is not buffered: its ready follows the stream ready directly. To bound how much data can be in flight, new bursts are requested only while the beats that are requested but not yet consumed stay within a fixed credit. Only one command is handled at a time.

Top module: `axi_rd_stream`

## Requirements
- R1: After reset, `m_arvalid`, `axis_tvalid` and `cmd_fin` are 0.
- R2: The first burst address equals `cmd_base`. Each later burst starts at the byte right after the previous burst, so the bursts cover `cmd_bytes` bytes with no gap and no overlap. Word n of the region is at `cmd_base + 4*n`.
- R3: `m_arlen` holds the burst beat count minus one, and no burst is longer than MAX_BURST (16) beats.
- R4: No burst crosses a 4096-byte address boundary.
- R5: While `m_arvalid` is high and `m_arready` is low, `m_arvalid`, `m_araddr` and `m_arlen` hold their values.
- R6: Read words appear on `axis_tdata` in address order, one stream beat per read beat. `m_rready` is low whenever `axis_tready` is low.
- R7: `axis_tlast` is high on the final word of the command and on no other word, and it coincides with `m_rlast`.
- R8: The number of beats requested but not yet taken by the stream never exceeds CREDIT (32). A new burst waits until it fits within that limit.
- R9: `cmd_fin` is high for exactly the one cycle after the last word is taken by the stream.
- R10: A `cmd_go` pulse while a command is in progress is ignored: it adds no bursts, no words and no completion pulse.
- R11: A command with a byte count of 0 issues no burst and raises `cmd_fin` in the next cycle. The two low bits of `cmd_bytes` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | One-cycle start pulse |
| cmd_base | input | 64 | Byte address of the region start |
| cmd_bytes | input | 32 | Region length in bytes (multiple of 4) |
| cmd_fin | output | 1 | One-cycle completion pulse |
| m_arvalid | output | 1 | Read-address valid |
| m_arready | input | 1 | Read-address ready |
| m_araddr | output | 64 | Burst start address |
| m_arlen | output | 8 | Burst beats minus one |
| m_rvalid | input | 1 | Read-data valid |
| m_rready | output | 1 | Read-data ready |
| m_rdata | input | 32 | Read data |
| m_rlast | input | 1 | Last beat of a burst |
| axis_tvalid | output | 1 | Stream valid |
| axis_tready | input | 1 | Stream ready |
| axis_tdata | output | 32 | Stream data |
| axis_tlast | output | 1 | Final word of the command |

## Verification
A wrong address register or remaining-beat counter shows up at the next read-address handshake as a non-contiguous `m_araddr`, an oversized `m_arlen`, or a burst that crosses a 4 KB boundary. A wrong receive counter shows up on the final stream beat as a misplaced `axis_tlast`, or as `cmd_fin` arriving early, late or not at all. A credit counter that drifts shows up within a few bursts when the read-data channel is stalled, as more beats in flight than CREDIT allows. Stimulus covers several stream back-pressure patterns, regions that straddle 4 KB boundaries, single-word and zero-length commands, and a start pulse issued mid-transfer.

// File: rtl/axi_rd_stream.sv
module axi_rd_stream #(
  parameter int ADDR_W    = 64,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 32,
  parameter int MAX_BURST = 16,
  parameter int CREDIT    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [ADDR_W-1:0] cmd_base,
  input  logic [LEN_W-1:0]  cmd_bytes,
  output logic              cmd_fin,
  output logic              m_arvalid,
  input  logic              m_arready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  input  logic              m_rvalid,
  output logic              m_rready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_rlast,
  output logic              axis_tvalid,
  input  logic              axis_tready,
  output logic [DATA_W-1:0] axis_tdata,
  output logic              axis_tlast
);
  localparam int BW  = LEN_W - 2;
  localparam int CW  = $clog2(CREDIT + MAX_BURST + 1);
  localparam int BLW = $clog2(MAX_BURST + 1);

  logic              busy;
  logic [ADDR_W-1:0] addr_q;
  logic [BW-1:0]     issue_left, recv_left;
  logic [CW-1:0]     outst;
  logic [BLW-1:0]    blen;
  logic              can_issue, r_hs, last_hs;

  always_comb begin
    int cand, room;
    room = (4096 - int'(addr_q[11:0])) / 4;
    cand = (issue_left > BW'(MAX_BURST)) ? MAX_BURST : int'(issue_left);
    if (cand > room) cand = room;
    blen = BLW'(cand);
  end

  assign can_issue = busy && !m_arvalid && (issue_left != '0) &&
                     ((int'(outst) + int'(blen)) <= CREDIT);
  assign m_rready    = busy && axis_tready;
  assign axis_tvalid = busy && m_rvalid;
  assign axis_tdata  = m_rdata;
  assign axis_tlast  = busy && (recv_left == BW'(1));
  assign r_hs        = m_rvalid && m_rready;
  assign last_hs     = r_hs && (recv_left == BW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      addr_q     <= '0;
      issue_left <= '0;
      recv_left  <= '0;
      outst      <= '0;
      m_arvalid  <= 1'b0;
      m_araddr   <= '0;
      m_arlen    <= '0;
      cmd_fin    <= 1'b0;
    end else begin
      cmd_fin <= 1'b0;
      if (!busy && cmd_go) begin
        if (cmd_bytes[LEN_W-1:2] == '0) begin
          cmd_fin <= 1'b1;
        end else begin
          busy       <= 1'b1;
          addr_q     <= cmd_base;
          issue_left <= cmd_bytes[LEN_W-1:2];
          recv_left  <= cmd_bytes[LEN_W-1:2];
        end
      end
      if (can_issue) begin
        m_arvalid  <= 1'b1;
        m_araddr   <= addr_q;
        m_arlen    <= 8'(blen) - 8'd1;
        addr_q     <= addr_q + ADDR_W'({blen, 2'b00});
        issue_left <= issue_left - BW'(blen);
      end else if (m_arvalid && m_arready) begin
        m_arvalid <= 1'b0;
      end
      outst <= outst + (can_issue ? CW'(blen) : CW'(0)) - (r_hs ? CW'(1) : CW'(0));
      if (r_hs) begin
        recv_left <= recv_left - BW'(1);
        if (last_hs) begin
          busy    <= 1'b0;
          cmd_fin <= 1'b1;
        end
      end
    end
  end

  assert_len_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (int'(m_arlen) < MAX_BURST));

  assert_no_4k_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> (int'(m_araddr[11:0]) + 4 * (int'(m_arlen) + 1) <= 4096));

  assert_ar_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr) && $stable(m_arlen)));

  assert_stream_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !axis_tready |-> !m_rready);

  assert_tlast_rlast_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (axis_tvalid && axis_tlast) |-> m_rlast);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(outst) <= CREDIT);

  assert_fin_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fin |-> (!axis_tvalid && !m_arvalid));
endmodule

// File: tb/axi_rd_stream_test.sv
`timescale 1ns/1ps
module axi_rd_stream_test;
  localparam int CREDIT = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 1'b0, cmd_fin;
  logic [63:0] cmd_base = '0;
  logic [31:0] cmd_bytes = '0;
  logic m_arvalid, m_arready = 1'b0;
  logic [63:0] m_araddr;
  logic [7:0] m_arlen;
  logic m_rvalid = 1'b0, m_rready, m_rlast = 1'b0;
  logic [31:0] m_rdata = '0;
  logic axis_tvalid, axis_tready = 1'b0, axis_tlast;
  logic [31:0] axis_tdata;

  always #2.5 clk = ~clk;

  axi_rd_stream uut (.*);

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [63:0] a);
    return (a[31:0] * 32'h9E37) ^ a[63:32];
  endfunction

  int tmode = 0;
  bit rstall = 1'b0;
  logic [63:0] exp_base, exp_next;
  int exp_total, exp_idx, ar_beats, outst, fin_cnt, bad_ar, bad_data, bad_last, bad_fin;
  int cyc = 0, last_cyc = -10;
  logic [63:0] q_addr [0:63];
  int q_len [0:63];
  int qh = 0, qt = 0, beat = 0;

  always begin
    @(negedge clk);
    cyc++;
    m_arready = (cyc % 3) != 1;
    axis_tready = (tmode == 0) ? 1'b1 : (tmode == 1) ? ((cyc % 4) != 0) : ((cyc % 2) == 0);
    m_rvalid = (qh != qt) && !rstall && ((cyc % 5) != 2);
    m_rdata = (qh != qt) ? memf(q_addr[qh] + 64'(4 * beat)) : 32'h0;
    m_rlast = (qh != qt) && (beat == q_len[qh]);
    #1;
    if (rst_n) begin
      if (cmd_fin) begin
        fin_cnt++;
        if (exp_total != 0 && last_cyc != cyc - 1) bad_fin++;
      end
      if (m_arvalid && m_arready) begin
        if (m_araddr != exp_next || m_arlen > 8'd15 ||
            (int'(m_araddr[11:0]) + 4 * (int'(m_arlen) + 1)) > 4096) bad_ar++;
        exp_next = m_araddr + 64'(4 * (int'(m_arlen) + 1));
        q_addr[qt] = m_araddr; q_len[qt] = int'(m_arlen); qt = (qt + 1) % 64;
        ar_beats += int'(m_arlen) + 1;
        outst += int'(m_arlen) + 1;
        if (outst > CREDIT) bad_ar++;
      end
      if (m_rvalid && m_rready) begin
        if (!axis_tvalid || axis_tdata != memf(exp_base + 64'(4 * exp_idx))) bad_data++;
        if (axis_tlast != (exp_idx == exp_total - 1)) bad_last++;
        if (exp_idx == exp_total - 1) last_cyc = cyc;
        exp_idx++; outst--;
        if (beat == q_len[qh]) begin beat = 0; qh = (qh + 1) % 64; end
        else beat++;
      end
    end
  end

  task automatic arm(input logic [63:0] b, input int bytes);
    exp_base = b; exp_next = b; exp_total = bytes / 4; exp_idx = 0;
    ar_beats = 0; fin_cnt = 0; bad_ar = 0; bad_data = 0; bad_last = 0; bad_fin = 0;
  endtask

  task automatic pulse(input logic [63:0] b, input logic [31:0] bytes);
    @(negedge clk); cmd_base = b; cmd_bytes = bytes; cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0;
  endtask

  task automatic wait_fin(input string req);
    int n = 0;
    while (fin_cnt == 0 && n < 5000) begin @(negedge clk); n++; end
    chk(fin_cnt != 0, {req, " watchdog"}, n, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic verify(input string tag);
    chk(bad_ar == 0, {tag, " R2/R3/R4/R8 bursts"}, bad_ar, 0);
    chk(ar_beats == exp_total, {tag, " R2 coverage"}, ar_beats, exp_total);
    chk(bad_data == 0 && exp_idx == exp_total, {tag, " R6 data"}, exp_idx, exp_total);
    chk(bad_last == 0, {tag, " R7 tlast"}, bad_last, 0);
    chk(fin_cnt == 1 && bad_fin == 0, {tag, " R9 fin"}, fin_cnt, 1);
  endtask

  localparam logic [97:0] VEC [0:4] = '{
    {64'h0000_0000_0000_1000, 32'd64,  2'd0},
    {64'h0000_0000_0000_0FF0, 32'd48,  2'd1},
    {64'h0000_0001_0000_2FC0, 32'd400, 2'd2},
    {64'h0000_0000_0000_0020, 32'd4,   2'd0},
    {64'h0000_0000_0000_3F04, 32'd260, 2'd1}
  };

  initial begin
    arm(64'h0, 0);
    repeat (3) @(negedge clk);
    #2;
    chk(!m_arvalid && !axis_tvalid && !cmd_fin, "R1 reset", {m_arvalid, axis_tvalid, cmd_fin}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!m_arvalid && !axis_tvalid && !cmd_fin, "R1 idle", {m_arvalid, axis_tvalid, cmd_fin}, 0);

    for (int i = 0; i < 5; i++) begin
      tmode = int'(VEC[i][1:0]);
      arm(VEC[i][97:34], int'(VEC[i][33:2]));
      pulse(VEC[i][97:34], VEC[i][33:2]);
      wait_fin("vector");
      verify($sformatf("vec%0d", i));
    end

    // R10: second start mid-transfer is ignored
    tmode = 1;
    arm(64'h5000, 256);
    pulse(64'h5000, 32'd256);
    repeat (10) @(negedge clk);
    pulse(64'h9000, 32'd8);
    wait_fin("R10");
    repeat (20) @(negedge clk);
    verify("R10 busy-start");

    // R8: stalled read data, credit limits requests
    tmode = 0; rstall = 1'b1;
    arm(64'h0, 512);
    pulse(64'h0, 32'd512);
    repeat (40) @(negedge clk); #2;
    chk(ar_beats == CREDIT, "R8 credit stop", ar_beats, CREDIT);
    chk(!m_arvalid, "R8 no request beyond credit", m_arvalid, 0);
    rstall = 1'b0;
    wait_fin("R8");
    verify("R8 drain");

    // R11: zero count, low bits ignored
    arm(64'h7000, 0);
    @(negedge clk); cmd_base = 64'h7000; cmd_bytes = 32'd3; cmd_go = 1'b1;
    @(negedge clk); cmd_go = 1'b0; #2;
    chk(cmd_fin, "R11 fin next cycle", cmd_fin, 1);
    repeat (10) @(negedge clk);
    chk(ar_beats == 0 && exp_idx == 0 && fin_cnt == 1, "R11 no traffic", ar_beats, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #900000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule